// File: doc/BRIEF.md
# Decimal-Capable 16-bit ALU with Flag Generation

This block is the purely combinational arithmetic-logic unit of a small 16-bit core. It takes two operands, a 4-bit operation code, a 2-bit shift-amount code and the current carry and half-carry, and returns a result together with a new flag vector. It covers add, subtract, compare, the three bitwise operations, byte swap, a family of shifts and rotates with fixed amounts, and a decimal adjust that corrects a byte after packed-BCD addition.

The flag vector uses fixed bit positions that the core's flag register decodes: negative at bit 7, zero at bit 6, carry at bit 5, signed overflow at bit 4 and half-carry at bit 3. Bit 2 holds the interrupt enable, and the ALU never drives or marks it. A flag-write mask of the same layout tells the core which flag bits the selected operation updates; bits outside the mask keep their stored value. A separate register-write strobe is low for compare and for the unused operation code.

The core applies `result_o` to its destination register when `rd_we_o` is high. It merges `flags_o` into its flag register under `fmask_o`.

Top module: `bcd_alu`

## Requirements
- R1: Operation code 0 (add) returns `a_i + b_i` modulo 2^16. Carry (flag bit 5) is the carry out of bit 15.
- R2: Operation code 1 (subtract) returns `a_i - b_i` modulo 2^16. Carry (bit 5) is set exactly when `a_i < b_i` as unsigned values, so it acts as a borrow.
- R3: For add, subtract and compare, overflow (flag bit 4) is set exactly when the signed result cannot be represented in 16 bits.
- R4: For add, half-carry (flag bit 3) is the carry out of bit 3. For subtract and compare it is set when the low nibble of `a_i` is below the low nibble of `b_i`.
- R5: Whenever the mask marks them, negative (flag bit 7) equals bit 15 of `result_o`, and zero (flag bit 6) is set exactly when `result_o` is 0.
- R6: Operation code 2 (compare) produces the same flags as subtract, with `rd_we_o` low.
- R7: Codes 3, 4, 5 and 6 (AND, OR, XOR, byte swap of `a_i`) write N, Z, C and V with C and V cleared. They leave H out of the mask.
- R8: Codes 8, 9 and 10 (logical left, logical right, arithmetic right) shift `a_i` by 1, 4 or 8 bits for `amt_i` = 0, 1 or 2/3. C takes the last bit shifted out and V is cleared.
- R9: Codes 11 and 12 rotate `a_i` left or right by the selected amount. C takes the last bit that crossed the word edge and V is cleared.
- R10: Codes 13 and 14 rotate the 17-bit value {carry, `a_i`} left or right by the selected amount. The new carry is bit 16 of the rotated value.
- R11: Code 7 (decimal adjust) acts on the low byte of `a_i` and keeps the high byte. It adds 0x06 when the original low nibble exceeds 9 or `h_i` is set. It adds 0x60 when the original byte exceeds 0x99 or `c_i` is set, and in that case C is set. Only N, Z and C are written.
- R12: The mask is 0xF8 for codes 0 to 2, 0xF0 for codes 3 to 6 and 8 to 14, and 0xE0 for code 7. Bits 2 to 0 of both `flags_o` and `fmask_o` are always 0. Code 15 gives result 0, mask 0 and `rd_we_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand; sole operand for shifts, swap and decimal adjust |
| b_i | input | 16 | Second operand |
| op_i | input | 4 | Operation code |
| amt_i | input | 2 | Shift amount code: 0 selects 1, 1 selects 4, 2 or 3 selects 8 |
| c_i | input | 1 | Current carry flag |
| h_i | input | 1 | Current half-carry flag |
| result_o | output | 16 | Operation result |
| flags_o | output | 8 | New flag values: N bit 7, Z bit 6, C bit 5, V bit 4, H bit 3 |
| fmask_o | output | 8 | Flag bits the operation updates |
| rd_we_o | output | 1 | Result is to be written to the destination register |

## Verification
The block holds no state, so a fault in an internal path shows at the ports in the same evaluation as the stimulus that exercises it. A wrong nibble carry in the adder shows as a bad half-carry and a bad upper result together. A wrong lane in the shifter shows only for the one amount code that selects it. For that reason every shift kind is driven with all three amounts, and decimal adjust is driven with each combination of nibble range and incoming flags. Masked flag values are compared exactly, and the mask itself is compared on every vector, so an operation that claims a flag it should leave alone is caught at once.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_CMP  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_SWAP = 4'd6,
      OP_DAA  = 4'd7,
      OP_SLL  = 4'd8,
      OP_SRL  = 4'd9,
      OP_SRA  = 4'd10,
      OP_ROL  = 4'd11,
      OP_ROR  = 4'd12,
      OP_RCL  = 4'd13,
      OP_RCR  = 4'd14,
      OP_NONE = 4'd15
   } alu_op_e;

   // low three bits of the shift-family operation codes
   typedef enum logic [2:0] {
      SH_SLL = 3'd0,
      SH_SRL = 3'd1,
      SH_SRA = 3'd2,
      SH_ROL = 3'd3,
      SH_ROR = 3'd4,
      SH_RCL = 3'd5,
      SH_RCR = 3'd6
   } shift_kind_e;

   localparam int FLAG_W = 8;
   localparam int FB_N   = 7;
   localparam int FB_Z   = 6;
   localparam int FB_C   = 5;
   localparam int FB_V   = 4;
   localparam int FB_H   = 3;
   localparam int FB_I   = 2;

   localparam logic [FLAG_W-1:0] M_ARITH = 8'hF8;
   localparam logic [FLAG_W-1:0] M_NZCV  = 8'hF0;
   localparam logic [FLAG_W-1:0] M_NZC   = 8'hE0;

endpackage

// File: rtl/bcd_alu_addsub.sv
module bcd_alu_addsub #(
   parameter int W   = 16,
   parameter int NIB = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         c_out,
   output logic         v_out,
   output logic         h_out
);
   localparam int HI_W = W - NIB;

   logic [W-1:0]  b_eff;
   logic [NIB:0]  low;
   logic [HI_W:0] high;

   if (NIB < 1 || NIB >= W) begin : g_bad_nib
      $error("bcd_alu_addsub: NIB out of range");
   end

   assign b_eff = sub ? ~b : b;
   assign low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub};
   assign high  = {1'b0, a[W-1:NIB]} + {1'b0, b_eff[W-1:NIB]} + {{HI_W{1'b0}}, low[NIB]};
   assign sum   = {high[HI_W-1:0], low[NIB-1:0]};
   assign c_out = sub ? ~high[HI_W] : high[HI_W];
   assign h_out = sub ? ~low[NIB]   : low[NIB];
   assign v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

   always_comb begin
      if (!sub) begin
         p_add_sum_r1: assert ({c_out, sum} == ({1'b0, a} + {1'b0, b}));
         p_add_half_r4: assert (h_out == (({1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]}) > {1'b0, {NIB{1'b1}}}));
      end else begin
         p_sub_borrow_r2: assert (c_out == (a < b));
         p_sub_half_r4: assert (h_out == (a[NIB-1:0] < b[NIB-1:0]));
      end
   end

endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
   import bcd_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] res
);
   localparam int HALF = W / 2;

   logic [W-1:0] swapped;

   if (W % 2 != 0) begin : g_bad_w
      $error("bcd_alu_logic: W must be even");
   end

   assign swapped = {a[HALF-1:0], a[W-1:HALF]};

   always_comb begin
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_SWAP: res = swapped;
         default: res = a;
      endcase
   end

endmodule

// File: rtl/bcd_alu_daa.sv
module bcd_alu_daa #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic         c_in,
   input  logic         h_in,
   output logic [W-1:0] res,
   output logic         c_out
);
   localparam int BYTE = 8;

   logic            lo_fix;
   logic            hi_fix;
   logic [BYTE-1:0] adj;
   logic [BYTE-1:0] fixed;

   if (W < 2 * BYTE) begin : g_bad_w
      $error("bcd_alu_daa: W must hold at least two bytes");
   end

   assign lo_fix = (a[3:0] > 4'd9) || h_in;
   assign hi_fix = (a[BYTE-1:0] > 8'h99) || c_in;
   assign adj    = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
   assign fixed  = a[BYTE-1:0] + adj;
   assign res    = {a[W-1:BYTE], fixed};
   assign c_out  = hi_fix;

   always_comb begin
      // a byte already holding two decimal digits passes unchanged
      if (!c_in && !h_in && a[3:0] <= 4'd9 && a[7:4] <= 4'd9) begin
         p_daa_clean_r11: assert (res == a && !c_out);
      end
   end

endmodule

// File: rtl/bcd_alu_shift.sv
module bcd_alu_shift
   import bcd_alu_pkg::*;
#(
   parameter int W    = 16,
   parameter int AMT0 = 1,
   parameter int AMT1 = 4,
   parameter int AMT2 = 8
) (
   input  logic [W-1:0] a,
   input  logic         c_in,
   input  shift_kind_e  kind,
   input  logic [1:0]   amt_sel,
   output logic [W-1:0] res,
   output logic         c_out
);
   localparam int NLANE = 3;

   logic [W-1:0] lane_r [NLANE];
   logic         lane_c [NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_amt
      localparam int K = (g == 0) ? AMT0 : (g == 1) ? AMT1 : AMT2;
      if (K < 1 || K >= W) begin : g_bad_k
         $error("bcd_alu_shift: shift amount out of range");
      end
      logic [W:0] x;
      logic [W:0] y;
      assign x = {c_in, a};
      always_comb begin
         y         = x;
         lane_r[g] = a;
         lane_c[g] = c_in;
         case (kind)
            SH_SLL: begin lane_r[g] = a << K; lane_c[g] = a[W-K]; end
            SH_SRL: begin lane_r[g] = a >> K; lane_c[g] = a[K-1]; end
            SH_SRA: begin lane_r[g] = $unsigned($signed(a) >>> K); lane_c[g] = a[K-1]; end
            SH_ROL: begin lane_r[g] = (a << K) | (a >> (W - K)); lane_c[g] = a[W-K]; end
            SH_ROR: begin lane_r[g] = (a >> K) | (a << (W - K)); lane_c[g] = a[K-1]; end
            SH_RCL: begin
               y         = (x << K) | (x >> (W + 1 - K));
               lane_r[g] = y[W-1:0];
               lane_c[g] = y[W];
            end
            SH_RCR: begin
               y         = (x >> K) | (x << (W + 1 - K));
               lane_r[g] = y[W-1:0];
               lane_c[g] = y[W];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (amt_sel)
         2'd0:    begin res = lane_r[0]; c_out = lane_c[0]; end
         2'd1:    begin res = lane_r[1]; c_out = lane_c[1]; end
         default: begin res = lane_r[2]; c_out = lane_c[2]; end
      endcase
   end

   always_comb begin
      if (kind == SH_ROL || kind == SH_ROR) begin
         p_rot_ones_r9: assert ($countones(res) == $countones(a));
      end
      if (kind == SH_RCL || kind == SH_RCR) begin
         p_rcx_ones_r10: assert ($countones({c_out, res}) == $countones({c_in, a}));
      end
   end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
   import bcd_alu_pkg::*;
#(
   parameter int W    = 16,
   parameter int AMT0 = 1,
   parameter int AMT1 = 4,
   parameter int AMT2 = 8
) (
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  logic [3:0]        op_i,
   input  logic [1:0]        amt_i,
   input  logic              c_i,
   input  logic              h_i,
   output logic [W-1:0]      result_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic [FLAG_W-1:0] fmask_o,
   output logic              rd_we_o
);
   localparam int NIB = 4;

   if (W < 16 || W % 8 != 0) begin : g_bad_w
      $error("bcd_alu: W must be a multiple of 8 and at least 16");
   end

   alu_op_e      op;
   logic         is_sub;
   logic [W-1:0] as_sum, lg_res, daa_res, sh_res;
   logic         as_c, as_v, as_h, daa_c, sh_c;
   logic [W-1:0] res;
   logic         c, v, h;

   assign op     = alu_op_e'(op_i);
   assign is_sub = (op == OP_SUB) || (op == OP_CMP);

   bcd_alu_addsub #(.W(W), .NIB(NIB)) u_addsub (
      .a(a_i), .b(b_i), .sub(is_sub),
      .sum(as_sum), .c_out(as_c), .v_out(as_v), .h_out(as_h)
   );

   bcd_alu_logic #(.W(W)) u_logic (
      .a(a_i), .b(b_i), .op(op), .res(lg_res)
   );

   bcd_alu_daa #(.W(W)) u_daa (
      .a(a_i), .c_in(c_i), .h_in(h_i), .res(daa_res), .c_out(daa_c)
   );

   bcd_alu_shift #(.W(W), .AMT0(AMT0), .AMT1(AMT1), .AMT2(AMT2)) u_shift (
      .a(a_i), .c_in(c_i), .kind(shift_kind_e'(op_i[2:0])), .amt_sel(amt_i),
      .res(sh_res), .c_out(sh_c)
   );

   always_comb begin
      res     = '0;
      c       = 1'b0;
      v       = 1'b0;
      h       = h_i;
      fmask_o = '0;
      rd_we_o = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_CMP: begin
            res     = as_sum;
            c       = as_c;
            v       = as_v;
            h       = as_h;
            fmask_o = M_ARITH;
            rd_we_o = (op != OP_CMP);
         end
         OP_AND, OP_OR, OP_XOR, OP_SWAP: begin
            res     = lg_res;
            fmask_o = M_NZCV;
            rd_we_o = 1'b1;
         end
         OP_DAA: begin
            res     = daa_res;
            c       = daa_c;
            fmask_o = M_NZC;
            rd_we_o = 1'b1;
         end
         OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
            res     = sh_res;
            c       = sh_c;
            fmask_o = M_NZCV;
            rd_we_o = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      flags_o       = '0;
      flags_o[FB_N] = res[W-1];
      flags_o[FB_Z] = ~|res;
      flags_o[FB_C] = c;
      flags_o[FB_V] = v;
      flags_o[FB_H] = h;
   end

   assign result_o = res;

   always_comb begin
      p_ibit_r12: assert (!fmask_o[FB_I] && !flags_o[FB_I]);
      if (op == OP_CMP) begin
         p_cmp_nowrite_r6: assert (!rd_we_o && fmask_o == M_ARITH && result_o == a_i - b_i);
      end
      if (op == OP_NONE) begin
         p_undef_r12: assert (fmask_o == '0 && !rd_we_o && result_o == '0);
      end
      if (fmask_o[FB_Z]) begin
         p_zero_r5: assert (flags_o[FB_Z] == (result_o == '0));
      end
   end

endmodule

// File: tb/bcd_alu_tb.sv
module bcd_alu_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   typedef struct packed {
      logic [15:0] r;
      logic [7:0]  f;
      logic [7:0]  m;
      logic        we;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] a_i = '0, b_i = '0;
   logic [3:0]  op_i = '0;
   logic [1:0]  amt_i = '0;
   logic        c_i = 1'b0, h_i = 1'b0;
   logic [15:0] result_o;
   logic [7:0]  flags_o, fmask_o;
   logic        rd_we_o;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   bcd_alu u_dut (
      .a_i(a_i), .b_i(b_i), .op_i(op_i), .amt_i(amt_i), .c_i(c_i), .h_i(h_i),
      .result_o(result_o), .flags_o(flags_o), .fmask_o(fmask_o), .rd_we_o(rd_we_o)
   );

   // reference model written from the requirements
   function automatic exp_t model(input logic [3:0] op, input logic [1:0] amt,
                                  input logic [15:0] a, input logic [15:0] b,
                                  input logic c, input logic h);
      exp_t        e;
      logic [16:0] s;
      logic [15:0] x;
      logic        cc, vv, hh, t;
      int          k;
      logic [8:0]  d;
      cc = 1'b0; vv = 1'b0; hh = h;
      e.we = 1'b1;
      e.m  = 8'hF0;
      x    = '0;
      k    = (amt == 2'd0) ? 1 : (amt == 2'd1) ? 4 : 8;
      case (op)
         4'd0: begin
            s = {1'b0, a} + {1'b0, b}; x = s[15:0]; cc = s[16];
            vv = (a[15] == b[15]) && (x[15] != a[15]);
            hh = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            e.m = 8'hF8;
         end
         4'd1, 4'd2: begin
            x = a - b; cc = a < b;
            vv = (a[15] != b[15]) && (x[15] != a[15]);
            hh = a[3:0] < b[3:0];
            e.m = 8'hF8;
            e.we = (op == 4'd1);
         end
         4'd3: x = a & b;
         4'd4: x = a | b;
         4'd5: x = a ^ b;
         4'd6: x = {a[7:0], a[15:8]};
         4'd7: begin
            d = {1'b0, a[7:0]};
            if (a[3:0] > 4'd9 || h) d = d + 9'h006;
            if (a[7:0] > 8'h99 || c) begin d = d + 9'h060; cc = 1'b1; end
            x = {a[15:8], d[7:0]};
            e.m = 8'hE0;
         end
         4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14: begin
            x = a; cc = c;
            for (int i = 0; i < k; i++) begin
               case (op)
                  4'd8:  begin cc = x[15]; x = {x[14:0], 1'b0}; end
                  4'd9:  begin cc = x[0];  x = {1'b0, x[15:1]}; end
                  4'd10: begin cc = x[0];  x = {x[15], x[15:1]}; end
                  4'd11: begin cc = x[15]; x = {x[14:0], x[15]}; end
                  4'd12: begin cc = x[0];  x = {x[0], x[15:1]}; end
                  4'd13: begin t = x[15];  x = {x[14:0], cc}; cc = t; end
                  default: begin t = x[0]; x = {cc, x[15:1]}; cc = t; end
               endcase
            end
         end
         default: begin x = '0; e.m = 8'h00; e.we = 1'b0; end
      endcase
      e.r = x;
      e.f = {x[15], (x == 16'h0), cc, vv, hh, 3'b000};
      return e;
   endfunction

   task automatic apply(input logic [3:0] op, input logic [1:0] amt,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic c, input logic h, input string tag);
      @(posedge clk);
      op_i = op; amt_i = amt; a_i = a; b_i = b; c_i = c; h_i = h;
      exp_q.push_back(model(op, amt, a, b, c, h));
      tag_q.push_back(tag);
   endtask

   // monitor: compare at the falling edge, away from the driving edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t  e;
         string tg;
         e  = exp_q.pop_front();
         tg = tag_q.pop_front();
         checks++;
         if (result_o !== e.r || fmask_o !== e.m || rd_we_o !== e.we ||
             (flags_o & e.m) !== (e.f & e.m) || flags_o[2:0] !== 3'b000) begin
            errors++;
            $display("FAIL %s op=%0d amt=%0d a=%h b=%h c=%b h=%b: got r=%h f=%h m=%h we=%b exp r=%h f=%h m=%h we=%b",
                     tg, op_i, amt_i, a_i, b_i, c_i, h_i, result_o, flags_o, fmask_o, rd_we_o,
                     e.r, e.f & e.m, e.m, e.we);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      apply(4'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, "R5 reset state");
      // R1 add and carry
      apply(4'd0, 2'd0, 16'h1234, 16'h1111, 1'b0, 1'b0, "R1 add");
      apply(4'd0, 2'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, "R1 carry and zero");
      // R3 signed overflow
      apply(4'd0, 2'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, "R3 add overflow");
      apply(4'd1, 2'd0, 16'h8000, 16'h0001, 1'b0, 1'b0, "R3 sub overflow");
      // R4 half-carry and half-borrow
      apply(4'd0, 2'd0, 16'h000F, 16'h0001, 1'b0, 1'b0, "R4 half carry");
      apply(4'd1, 2'd0, 16'h0010, 16'h0001, 1'b0, 1'b0, "R4 half borrow");
      // R2 subtract and borrow
      apply(4'd1, 2'd0, 16'h0000, 16'h0001, 1'b0, 1'b0, "R2 borrow");
      apply(4'd1, 2'd0, 16'h5555, 16'h5555, 1'b0, 1'b0, "R2 equal");
      // R6 compare writes no register
      apply(4'd2, 2'd0, 16'h0003, 16'h0007, 1'b0, 1'b1, "R6 compare");
      // R7 logic and swap, H held out of mask
      apply(4'd3, 2'd0, 16'hF0F0, 16'h0FF0, 1'b1, 1'b1, "R7 and");
      apply(4'd4, 2'd0, 16'h8000, 16'h0001, 1'b1, 1'b0, "R7 or");
      apply(4'd5, 2'd0, 16'hA5A5, 16'hA5A5, 1'b0, 1'b1, "R7 xor zero");
      apply(4'd6, 2'd0, 16'h12AB, 16'h0000, 1'b1, 1'b1, "R7 swap");
      // R11 decimal adjust
      apply(4'd7, 2'd0, 16'h000F, 16'h0000, 1'b0, 1'b0, "R11 low fix");
      apply(4'd7, 2'd0, 16'h009A, 16'h0000, 1'b0, 1'b0, "R11 both fix wrap");
      apply(4'd7, 2'd0, 16'h0042, 16'h0000, 1'b1, 1'b0, "R11 carry in");
      apply(4'd7, 2'd0, 16'h8045, 16'h0000, 1'b0, 1'b0, "R11 clean byte");
      apply(4'd7, 2'd0, 16'h0031, 16'h0000, 1'b0, 1'b1, "R11 half in");
      // R8 R9 R10 every shift kind at every amount code
      for (int op = 8; op <= 14; op++) begin
         for (int am = 0; am < 4; am++) begin
            apply(op[3:0], am[1:0], 16'h8421, 16'h0000, 1'b0, 1'b1,
                  (op <= 10) ? "R8 shift" : (op <= 12) ? "R9 rotate" : "R10 carry rotate");
            apply(op[3:0], am[1:0], 16'hC003, 16'h0000, 1'b1, 1'b0,
                  (op <= 10) ? "R8 shift" : (op <= 12) ? "R9 rotate" : "R10 carry rotate");
         end
      end
      // R12 unused code
      apply(4'd15, 2'd0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R12 unused code");
      // R12 mask and flags across mixed vectors
      lfsr = 32'h1ACE_B00C;
      for (int n = 0; n < 400; n++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         apply(lfsr[3:0], lfsr[5:4], lfsr[31:16], {lfsr[15:6], lfsr[31:26]},
               lfsr[6], lfsr[7], "R12 mixed");
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule